// File: doc/BRIEF.md
# Double-Buffered DAC Command Register Bank

This block sits behind a two-wire serial slave front end and turns each received write word into register updates for a 10-bit voltage DAC. A write word has two bytes. The first byte carries a 4-bit command nibble in its upper half and the top four code bits in its lower half. The second byte carries the remaining six code bits, followed by two filler bits that should be zero. The bank holds a staging (input) register, a live DAC register and a 2-bit power-down register. It drives the live code, the power state and a one-hot termination selection to the analog side, and it always presents the two read-back bytes that the front end shifts out on a read.

The front end reports each received byte with a strobe. It reports a frame that ends early with an abort strobe. It reports the falling clock edge of the final acknowledge with a commit strobe. State changes only on that commit, and only when both bytes of the current word have arrived. The block comes out of reset with zero codes and in the 100k-terminated power-down state, so a wake-up command is needed before the output is driven.

Top module: `dac_cmd_bank`

## Requirements
- R1: After reset, dac_code is 0, pd_mode is 2'b11, out_drive is 0, term_sel is 3'b100, rd_byte_hi is 8'h30 and rd_byte_lo is 8'h00.
- R2: Command nibble 4'b1100 writes the 10-bit code {cmd_byte[3:0], data_byte[7:2]} into both registers, and dac_code shows it in the cycle after the commit.
- R3: Command nibble 4'b1101 writes the code into the input register only, and dac_code keeps its value.
- R4: Command nibble 4'b1110 writes the new code into the input register and moves the input register's previous value into the DAC register.
- R5: Command nibble 4'b1111 copies the input register into the DAC register and ignores the code bits; the input register keeps its value.
- R6: A command nibble with its top two bits equal to 2'b01 loads pd_mode from cmd_byte[3:2] and leaves both code registers unchanged. term_sel is one-hot: bit0 when pd_mode is 01 (floating), bit1 when it is 10 (1k), bit2 when it is 11 (100k). It is 0 and out_drive is 1 when pd_mode is 00.
- R7: rd_byte_hi is {2'b00, pd_mode, dac_code[9:6]} and rd_byte_lo is {dac_code[5:0], 2'b00}, whatever the filler bits of the written byte were.
- R8: A commit strobe changes nothing unless a command byte and a following data byte have both been received since the last commit or abort. An abort discards a partly received word.
- R9: A command nibble with top bits 2'b00 (read request) or 2'b10 (undefined) changes no register.
- R10: Code registers keep their values through power-down, including writes made while powered down, and waking with pd 00 drives the held code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_vld | input | 1 | Command byte received strobe |
| cmd_byte | input | 8 | Command nibble and code bits 9..6 |
| dat_vld | input | 1 | Data byte received strobe |
| data_byte | input | 8 | Code bits 5..0 and two filler bits |
| frame_abort | input | 1 | Frame ended before the word completed |
| ack_commit | input | 1 | Falling clock edge of the final acknowledge |
| dac_code | output | 10 | Live DAC register |
| pd_mode | output | 2 | Power-down register |
| out_drive | output | 1 | Output buffer enabled |
| term_sel | output | 3 | One-hot termination: float, 1k, 100k |
| rd_byte_hi | output | 8 | First read-back byte |
| rd_byte_lo | output | 8 | Second read-back byte |

## Verification
The bench builds the block with the default reset parameters: code 0 and the 100k power-down state. That makes the reset check and the first wake-up meaningful. The command sequence is ordered so that each double-buffer path leaves a different value in the input and DAC registers, and later transfer commands expose the hidden input register at the ports. Incomplete and aborted words, read and undefined nibbles, and writes made while powered down are each followed by a check of every output.

// File: rtl/dac_cmd_pkg.sv
// Package: shared widths, operation encoding and command decode for the
// DAC command register bank. Assumes a two-byte write word with a 4-bit
// command nibble at the top of the first byte.
package dac_cmd_pkg;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;
    localparam int SUB_W  = 2;
    localparam int PD_W   = 2;
    localparam int HI_W   = BYTE_W - NIB_W;                 // code bits in byte 1
    localparam int CODE_W = 2 * BYTE_W - NIB_W - SUB_W;     // 10
    localparam int LO_W   = CODE_W - HI_W;                  // code bits in byte 2
    localparam int PAD_W  = BYTE_W - PD_W - HI_W;           // read-back padding
    localparam int TERM_N = (1 << PD_W) - 1;                // termination choices

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [PD_W-1:0]   pd_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_LOAD_BOTH,
        OP_LOAD_IN,
        OP_LOAD_XFER,
        OP_XFER,
        OP_SET_PD,
        OP_READ
    } op_e;

    localparam pd_t PD_AWAKE = '0;

    // Map a command nibble to the operation it requests.
    function automatic op_e decode_cmd(input logic [NIB_W-1:0] c);
        op_e r;
        unique case (c[NIB_W-1 -: 2])
            2'b11: begin
                unique case (c[1:0])
                    2'b00:   r = OP_LOAD_BOTH;
                    2'b01:   r = OP_LOAD_IN;
                    2'b10:   r = OP_LOAD_XFER;
                    default: r = OP_XFER;
                endcase
            end
            2'b01:   r = OP_SET_PD;
            2'b00:   r = OP_READ;
            default: r = OP_NONE;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/cmd_stager.sv
// Module: cmd_stager
// Holds the bytes of the word in flight and says when a commit may apply.
// Assumes the front end raises dat_vld only after cmd_vld for the same word
// and raises ack_commit after the last byte has been reported.
module cmd_stager
    import dac_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_vld,
    input  logic [BYTE_W-1:0] cmd_byte,
    input  logic              dat_vld,
    input  logic [BYTE_W-1:0] data_byte,
    input  logic              frame_abort,
    input  logic              ack_commit,
    output logic [BYTE_W-1:0] hdr_q,
    output logic [BYTE_W-1:0] dat_q,
    output logic              commit_go
);
    logic hdr_ok;
    logic dat_ok;

    assign commit_go = ack_commit && hdr_ok && dat_ok;

    // Track which bytes of the current word have arrived.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_ok <= 1'b0;
            dat_ok <= 1'b0;
        end else if (frame_abort || commit_go) begin
            hdr_ok <= 1'b0;
            dat_ok <= 1'b0;
        end else if (cmd_vld) begin
            hdr_ok <= 1'b1;
            dat_ok <= 1'b0;
        end else if (dat_vld && hdr_ok) begin
            dat_ok <= 1'b1;
        end
    end

    // Capture the byte values themselves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q <= '0;
            dat_q <= '0;
        end else begin
            if (cmd_vld)           hdr_q <= cmd_byte;
            if (dat_vld && hdr_ok) dat_q <= data_byte;
        end
    end

    // A data byte alone never completes a word.
    AST_DATA_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_vld && !hdr_ok && !cmd_vld && !frame_abort && !commit_go) |=> !commit_go || !dat_ok) else $error("data without header"); // R8
endmodule

// File: rtl/cmd_decoder.sv
// Module: cmd_decoder
// Splits the staged word into an operation, a 10-bit code and a power-down
// field. Purely combinational; assumes the staged bytes are stable.
module cmd_decoder
    import dac_cmd_pkg::*;
(
    input  logic [BYTE_W-1:0] hdr_q,
    input  logic [BYTE_W-1:0] dat_q,
    output op_e               op,
    output code_t             new_code,
    output pd_t               new_pd
);
    // Operation, code field and power-down field of the staged word.
    always_comb begin
        op       = decode_cmd(hdr_q[BYTE_W-1 -: NIB_W]);
        new_code = {hdr_q[HI_W-1:0], dat_q[BYTE_W-1 -: LO_W]};
        new_pd   = hdr_q[HI_W-1 -: PD_W];
    end
endmodule

// File: rtl/dac_reg_file.sv
// Module: dac_reg_file
// Input, DAC and power-down registers. Changes happen only in the cycle a
// commit is granted; the operation picks which registers move.
module dac_reg_file
    import dac_cmd_pkg::*;
#(
    parameter logic [CODE_W-1:0] RESET_CODE = '0,
    parameter logic [PD_W-1:0]   RESET_PD   = '1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  commit_go,
    input  op_e   op,
    input  code_t new_code,
    input  pd_t   new_pd,
    output code_t dac_q,
    output pd_t   pd_q
);
    code_t in_q;

    // Apply the committed operation to the three registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q  <= RESET_CODE;
            dac_q <= RESET_CODE;
            pd_q  <= RESET_PD;
        end else if (commit_go) begin
            unique case (op)
                OP_LOAD_BOTH: begin
                    in_q  <= new_code;
                    dac_q <= new_code;
                end
                OP_LOAD_IN:   in_q <= new_code;
                OP_LOAD_XFER: begin
                    in_q  <= new_code;
                    dac_q <= in_q;
                end
                OP_XFER:      dac_q <= in_q;
                OP_SET_PD:    pd_q  <= new_pd;
                default: ;
            endcase
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dac_q == RESET_CODE && pd_q == RESET_PD)) else $error("reset state"); // R1
    AST_NO_COMMIT_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_go |=> ($stable(dac_q) && $stable(in_q) && $stable(pd_q))) else $error("change without commit"); // R8
    AST_LOAD_BOTH_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_go && op == OP_LOAD_BOTH) |=> (dac_q == in_q)) else $error("load both mismatch"); // R2
    AST_XFER_OLD_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_go && op == OP_LOAD_XFER) |=> (dac_q == $past(in_q))) else $error("transfer old value"); // R4
    AST_PD_KEEPS_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_go && (op == OP_SET_PD || op == OP_READ || op == OP_NONE)) |=> ($stable(dac_q) && $stable(in_q))) else $error("code moved"); // R6
endmodule

// File: rtl/dac_out_map.sv
// Module: dac_out_map
// Derives the buffer enable, one-hot termination select and read-back
// bytes from the register state. Combinational; one termination bit per
// non-zero power-down value.
module dac_out_map
    import dac_cmd_pkg::*;
(
    input  code_t              dac_q,
    input  pd_t                pd_q,
    output logic               out_drive,
    output logic [TERM_N-1:0]  term_sel,
    output logic [BYTE_W-1:0]  rd_byte_hi,
    output logic [BYTE_W-1:0]  rd_byte_lo
);
    // One termination bit per power-down value.
    for (genvar k = 0; k < TERM_N; k++) begin : g_term
        assign term_sel[k] = (pd_q == pd_t'(k + 1));
    end

    // Buffer enable and read-back byte packing.
    always_comb begin
        out_drive  = (pd_q == PD_AWAKE);
        rd_byte_hi = {{PAD_W{1'b0}}, pd_q, dac_q[CODE_W-1 -: HI_W]};
        rd_byte_lo = {dac_q[LO_W-1:0], {SUB_W{1'b0}}};
    end
endmodule

// File: rtl/dac_cmd_bank.sv
// Module: dac_cmd_bank (top)
// Double-buffered command register bank for a 10-bit DAC behind a serial
// slave front end. Assumes byte, abort and commit strobes are one-cycle
// pulses synchronous to clk.
module dac_cmd_bank
    import dac_cmd_pkg::*;
#(
    parameter logic [CODE_W-1:0] RESET_CODE = '0,
    parameter logic [PD_W-1:0]   RESET_PD   = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_vld,
    input  logic [7:0]        cmd_byte,
    input  logic              dat_vld,
    input  logic [7:0]        data_byte,
    input  logic              frame_abort,
    input  logic              ack_commit,
    output logic [9:0]        dac_code,
    output logic [1:0]        pd_mode,
    output logic              out_drive,
    output logic [2:0]        term_sel,
    output logic [7:0]        rd_byte_hi,
    output logic [7:0]        rd_byte_lo
);
    logic [BYTE_W-1:0] hdr_q;
    logic [BYTE_W-1:0] dat_q;
    logic              commit_go;
    op_e               op;
    code_t             new_code;
    pd_t               new_pd;
    code_t             dac_q;
    pd_t               pd_q;

    cmd_stager u_stage (
        .clk, .rst_n, .cmd_vld, .cmd_byte, .dat_vld, .data_byte,
        .frame_abort, .ack_commit, .hdr_q, .dat_q, .commit_go
    );

    cmd_decoder u_dec (
        .hdr_q, .dat_q, .op, .new_code, .new_pd
    );

    dac_reg_file #(.RESET_CODE(RESET_CODE), .RESET_PD(RESET_PD)) u_regs (
        .clk, .rst_n, .commit_go, .op, .new_code, .new_pd, .dac_q, .pd_q
    );

    dac_out_map u_map (
        .dac_q, .pd_q, .out_drive, .term_sel, .rd_byte_hi, .rd_byte_lo
    );

    assign dac_code = dac_q;
    assign pd_mode  = pd_q;

    AST_TERM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(term_sel) && (out_drive == (term_sel == '0))) else $error("termination select"); // R6
    AST_READBACK_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        {rd_byte_hi[3:0], rd_byte_lo[7:2]} == dac_code && rd_byte_lo[1:0] == 2'b00) else $error("read-back packing"); // R7
endmodule

// File: tb/sim_dac_cmd_bank.sv
// Scoreboard bench: the driver task updates a requirement-level model and
// pushes the expected port state; the monitor pops and compares.
module sim_dac_cmd_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_vld = 1'b0, dat_vld = 1'b0, frame_abort = 1'b0, ack_commit = 1'b0;
    logic [7:0] cmd_byte = '0, data_byte = '0;
    logic [9:0] dac_code;
    logic [1:0] pd_mode;
    logic       out_drive;
    logic [2:0] term_sel;
    logic [7:0] rd_byte_hi, rd_byte_lo;

    typedef struct {
        logic [9:0] code;
        logic [1:0] pd;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_run = 0, n_fail = 0;
    logic [9:0] m_in = '0, m_dac = '0;
    logic [1:0] m_pd = 2'b11;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    dac_cmd_bank u0 (
        .clk, .rst_n, .cmd_vld, .cmd_byte, .dat_vld, .data_byte,
        .frame_abort, .ack_commit, .dac_code, .pd_mode, .out_drive,
        .term_sel, .rd_byte_hi, .rd_byte_lo
    );

    // Monitor: compare every output against the oldest expected item.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            logic [2:0] t_exp;
            logic [7:0] hi_exp, lo_exp;
            e = exp_q.pop_front();
            t_exp  = (e.pd == 2'b00) ? 3'b000 : (3'b001 << (e.pd - 1));
            hi_exp = {2'b00, e.pd, e.code[9:6]};
            lo_exp = {e.code[5:0], 2'b00};
            n_run++;
            if (dac_code !== e.code || pd_mode !== e.pd || term_sel !== t_exp ||
                out_drive !== (e.pd == 2'b00) || rd_byte_hi !== hi_exp || rd_byte_lo !== lo_exp) begin
                n_fail++;
                $display("FAIL %s: code=%h pd=%b term=%b drv=%b hi=%h lo=%h expected code=%h pd=%b term=%b drv=%b hi=%h lo=%h",
                         e.tag, dac_code, pd_mode, term_sel, out_drive, rd_byte_hi, rd_byte_lo,
                         e.code, e.pd, t_exp, (e.pd == 2'b00), hi_exp, lo_exp);
            end
        end
    end

    task automatic push_exp(input string tag);
        exp_t e;
        e.code = m_dac; e.pd = m_pd; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Driver: one write word, optional data byte and abort, then commit.
    task automatic send_word(input logic [7:0] c, input logic [7:0] d,
                             input bit with_data, input bit abort, input string tag);
        logic [9:0] code;
        @(negedge clk); cmd_vld = 1'b1; cmd_byte = c;
        @(negedge clk); cmd_vld = 1'b0;
        if (with_data) begin
            dat_vld = 1'b1; data_byte = d;
            @(negedge clk); dat_vld = 1'b0;
        end
        if (abort) begin
            frame_abort = 1'b1;
            @(negedge clk); frame_abort = 1'b0;
        end
        ack_commit = 1'b1;
        @(negedge clk); ack_commit = 1'b0;
        code = {c[3:0], d[7:2]};
        if (with_data && !abort) begin
            case (c[7:4])
                4'b1100: begin m_in = code; m_dac = code; end
                4'b1101: m_in = code;
                4'b1110: begin m_dac = m_in; m_in = code; end
                4'b1111: m_dac = m_in;
                4'b0100, 4'b0101, 4'b0110, 4'b0111: m_pd = c[3:2];
                default: ;
            endcase
        end
        push_exp(tag);
        @(negedge clk); @(negedge clk);
    endtask

    function automatic logic [7:0] hb(input logic [3:0] nib, input logic [9:0] v);
        return {nib, v[9:6]};
    endfunction
    function automatic logic [7:0] lb(input logic [9:0] v, input logic [1:0] sub);
        return {v[5:0], sub};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        push_exp("R1 reset state");
        @(negedge clk); @(negedge clk);
        send_word(8'b0100_0000, 8'h00, 1, 0, "R6 R10 wake from reset");
        send_word(hb(4'b1100, 10'h2A5), lb(10'h2A5, 2'b00), 1, 0, "R2 load both");
        send_word(hb(4'b1101, 10'h155), lb(10'h155, 2'b00), 1, 0, "R3 input only");
        send_word(hb(4'b1110, 10'h0F0), lb(10'h0F0, 2'b00), 1, 0, "R4 load and move old input");
        send_word(hb(4'b1111, 10'h3FF), lb(10'h3FF, 2'b11), 1, 0, "R5 transfer ignores data");
        send_word(hb(4'b1110, 10'h001), lb(10'h001, 2'b00), 1, 0, "R5 input kept by transfer");
        send_word(hb(4'b1100, 10'h3C3), 8'h00, 0, 0, "R8 command byte only");
        send_word(hb(4'b1100, 10'h3C3), lb(10'h3C3, 2'b00), 1, 1, "R8 aborted word");
        send_word(8'b0000_1111, 8'hFF, 1, 0, "R9 read request");
        send_word(hb(4'b1000, 10'h2AA), lb(10'h2AA, 2'b00), 1, 0, "R9 undefined nibble");
        send_word(8'b0100_0100, 8'h00, 1, 0, "R6 float");
        send_word(hb(4'b1100, 10'h3FF), lb(10'h3FF, 2'b01), 1, 0, "R10 R7 write while down");
        send_word(8'b0100_1000, 8'h00, 1, 0, "R6 1k");
        send_word(8'b0110_1100, 8'h00, 1, 0, "R6 100k");
        send_word(8'b0100_0000, 8'h00, 1, 0, "R10 wake restores code");
        send_word(hb(4'b1111, 10'h000), lb(10'h000, 2'b00), 1, 0, "R5 transfer equal");
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run ends as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule